// File: doc/BRIEF.md
# Multilevel Program-and-Verify Sequencer

This block steps one resistive memory cell toward a requested state. It supports three operations: forming a pristine cell, resetting it to the single high-resistance level, and setting it to one of four low-resistance levels. In each step the block fires a voltage pulse of fixed length and waits a settle time. It then requests a read and compares the digitized read current with the target for the operation. If the target is met the sequence ends. If not, the pulse amplitude goes up by one code and the next step follows.

The block drives the programming interface: an amplitude code in 0.1 V units, a gate bias code in 0.1 V units, a terminal select and a pulse strobe. Analog drivers outside the block turn these into voltages. A sense path outside the block answers each read request with a current value in µA, marked by a valid strobe. When the sequence ends, the block flags success or failure and reports how many pulses it applied.

Top module: `mlc_prog_ctrl`

## Requirements
- R1: A command is taken only while the block is idle (`busy` low) and only with `cmdOp` 0 (form), 1 (reset) or 2 (set). `cmdValid` while busy, or with `cmdOp` 3, has no effect.
- R2: Every programming pulse is followed by exactly one verify read before the next pulse, and `pulseEn` and `readReq` are never high together.
- R3: `pulseEn` stays high for exactly PULSE_CYC cycles with a steady amplitude. After it drops, `readReq` rises after exactly SETTLE_CYC cycles.
- R4: The first pulse amplitude is code 2 for form and code 1 for reset and set. Each following pulse in the same sequence is exactly one code higher.
- R5: Reset pulses drive the source side (`drvSource`=1) with gate code 27. The sequence ends successfully on the first read below 5 µA.
- R6: Set to level k (`cmdLevel`=0..3 meaning L2..L5) drives the drain side (`drvSource`=0) with gate code 10+2k. It ends successfully on the first read of at least 15·(k+1) µA.
- R7: Form drives the drain side with gate code 15. It ends successfully on the first read strictly above 18 µA.
- R8: The amplitude never exceeds code 30. If the verify after a pulse at code 30 misses the target, the sequence ends with `fail`.
- R9: A new command clears `done` and `fail`. When a sequence ends, exactly one of them is raised, and it is held together with `pulseCount`, the number of pulses applied, until the next accepted command.
- R10: After reset the block is idle, and all of its outputs are zero. While idle, `pulseAmp`, `gateCode`, `drvSource`, `pulseEn` and `readReq` stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 0 form, 1 reset, 2 set, 3 unused |
| cmdLevel | input | 2 | Set target level, 0..3 for L2..L5 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence met its target |
| fail | output | 1 | Last sequence ran out of amplitude |
| pulseCount | output | 5 | Pulses applied in the current or last sequence |
| pulseAmp | output | 5 | Pulse amplitude code, 0.1 V per step |
| gateCode | output | 5 | Select gate bias code, 0.1 V per step |
| drvSource | output | 1 | 1 drives the source side, 0 drives the drain side |
| pulseEn | output | 1 | Programming pulse active |
| readReq | output | 1 | Verify read request |
| readValid | input | 1 | Read result strobe |
| readCurrent | input | 8 | Digitized read current in µA |

## Verification
The bound checker watches the cycle-level invariants on every cycle. These are the amplitude ceiling, the exclusion of pulse and read, a steady amplitude during a pulse, the one-code step between pulses, the reset gate bias on the source side, quiet outputs while idle, and the holding of `done`. Other properties depend on how the cell responds. Only the bench scenarios can show them: the stopping point for each operation and level, the strict and inclusive comparisons at the exact threshold currents, exhaustion at code 30, and commands ignored during a run. The bench drives a behavioural cell whose current moves with pulse amplitude and compares against pulse counts predicted in advance.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  typedef enum logic [1:0] {OP_FORM = 2'd0, OP_RESET = 2'd1, OP_SET = 2'd2, OP_NONE = 2'd3} opE;
  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_SETTLE, ST_VERIFY} stE;
  typedef struct packed {
    logic load;
    logic ampStep;
    logic tmrClr;
    logic finishOk;
    logic finishBad;
  } ctlStrobeT;
endpackage

// File: rtl/mlc_prog_dp.sv
module mlc_prog_dp
  import mlc_pkg::*;
#(
  parameter int AMP_W = 5,
  parameter int GATE_W = 5,
  parameter int CUR_W = 8,
  parameter int CNT_W = 5,
  parameter int TMR_W = 3,
  parameter int TMR_MAX = 4,
  parameter int AMP_MAX = 30,
  parameter int FORM_START = 2,
  parameter int PROG_START = 1,
  parameter int FORM_GATE = 15,
  parameter int RESET_GATE = 27,
  parameter int SET_GATE_BASE = 10,
  parameter int SET_GATE_STEP = 2,
  parameter int FORM_UA = 18,
  parameter int RESET_UA = 5,
  parameter int SET_STEP_UA = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobeT        strobe,
  input  logic [1:0]       cmdOp,
  input  logic [1:0]       cmdLevel,
  input  logic [CUR_W-1:0] readCurrent,
  input  logic             active,
  output logic [TMR_W-1:0] tmr,
  output logic             verifyPass,
  output logic             ampAtMax,
  output logic [AMP_W-1:0] ampOut,
  output logic [GATE_W-1:0] gateOut,
  output logic             sourceSide,
  output logic [CNT_W-1:0] pulseCnt,
  output logic             doneFlag,
  output logic             failFlag
);
  localparam int TGT_W = CUR_W + 3;

  opE               opReg;
  logic [1:0]       lvlReg;
  logic [AMP_W-1:0] amp;
  logic [TGT_W-1:0] setTarget;
  logic [TGT_W-1:0] curWide;
  logic [GATE_W-1:0] gateSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg    <= OP_FORM;
      lvlReg   <= '0;
      amp      <= '0;
      pulseCnt <= '0;
      doneFlag <= 1'b0;
      failFlag <= 1'b0;
    end else begin
      if (strobe.load) begin
        opReg    <= opE'(cmdOp);
        lvlReg   <= cmdLevel;
        amp      <= (opE'(cmdOp) == OP_FORM) ? AMP_W'(FORM_START) : AMP_W'(PROG_START);
        pulseCnt <= CNT_W'(1);
        doneFlag <= 1'b0;
        failFlag <= 1'b0;
      end else if (strobe.ampStep) begin
        amp      <= amp + AMP_W'(1);
        pulseCnt <= pulseCnt + CNT_W'(1);
      end
      if (strobe.finishOk) doneFlag <= 1'b1;
      if (strobe.finishBad) failFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmr <= '0;
    else if (strobe.tmrClr) tmr <= '0;
    else if (tmr < TMR_W'(TMR_MAX)) tmr <= tmr + TMR_W'(1);
  end

  assign curWide   = TGT_W'(readCurrent);
  assign setTarget = TGT_W'(SET_STEP_UA) * (TGT_W'(lvlReg) + TGT_W'(1));

  always_comb begin
    unique case (opReg)
      OP_FORM:  verifyPass = curWide > TGT_W'(FORM_UA);
      OP_RESET: verifyPass = curWide < TGT_W'(RESET_UA);
      OP_SET:   verifyPass = curWide >= setTarget;
      default:  verifyPass = 1'b0;
    endcase
  end

  always_comb begin
    unique case (opReg)
      OP_FORM:  gateSel = GATE_W'(FORM_GATE);
      OP_RESET: gateSel = GATE_W'(RESET_GATE);
      OP_SET:   gateSel = GATE_W'(SET_GATE_BASE) + GATE_W'(SET_GATE_STEP) * GATE_W'(lvlReg);
      default:  gateSel = '0;
    endcase
  end

  assign ampAtMax   = amp >= AMP_W'(AMP_MAX);
  assign ampOut     = active ? amp : '0;
  assign gateOut    = active ? gateSel : '0;
  assign sourceSide = active && (opReg == OP_RESET);
endmodule

// File: rtl/mlc_prog_ctl.sv
module mlc_prog_ctl
  import mlc_pkg::*;
#(
  parameter int TMR_W = 3,
  parameter int PULSE_CYC = 4,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic             readValid,
  input  logic             verifyPass,
  input  logic             ampAtMax,
  input  logic [TMR_W-1:0] tmr,
  output ctlStrobeT        strobe,
  output stE               state
);
  stE nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid && (opE'(cmdOp) != OP_NONE)) begin
          strobe.load   = 1'b1;
          strobe.tmrClr = 1'b1;
          nextState     = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (tmr == TMR_W'(PULSE_CYC - 1)) begin
          strobe.tmrClr = 1'b1;
          nextState     = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (tmr == TMR_W'(SETTLE_CYC - 1)) nextState = ST_VERIFY;
      end
      ST_VERIFY: begin
        if (readValid) begin
          if (verifyPass) begin
            strobe.finishOk = 1'b1;
            nextState       = ST_IDLE;
          end else if (ampAtMax) begin
            strobe.finishBad = 1'b1;
            nextState        = ST_IDLE;
          end else begin
            strobe.ampStep = 1'b1;
            strobe.tmrClr  = 1'b1;
            nextState      = ST_PULSE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/mlc_prog_ctrl.sv
module mlc_prog_ctrl
  import mlc_pkg::*;
#(
  parameter int AMP_W = 5,
  parameter int GATE_W = 5,
  parameter int CUR_W = 8,
  parameter int CNT_W = 5,
  parameter int PULSE_CYC = 4,
  parameter int SETTLE_CYC = 2,
  parameter int AMP_MAX = 30,
  parameter int FORM_START = 2,
  parameter int PROG_START = 1,
  parameter int FORM_GATE = 15,
  parameter int RESET_GATE = 27,
  parameter int SET_GATE_BASE = 10,
  parameter int SET_GATE_STEP = 2,
  parameter int FORM_UA = 18,
  parameter int RESET_UA = 5,
  parameter int SET_STEP_UA = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [1:0]        cmdLevel,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  pulseCount,
  output logic [AMP_W-1:0]  pulseAmp,
  output logic [GATE_W-1:0] gateCode,
  output logic              drvSource,
  output logic              pulseEn,
  output logic              readReq,
  input  logic              readValid,
  input  logic [CUR_W-1:0]  readCurrent
);
  localparam int TMR_MAX = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  ctlStrobeT        strobe;
  stE               state;
  logic [TMR_W-1:0] tmr;
  logic             verifyPass;
  logic             ampAtMax;

  mlc_prog_ctl #(
    .TMR_W(TMR_W), .PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .readValid(readValid), .verifyPass(verifyPass), .ampAtMax(ampAtMax),
    .tmr(tmr), .strobe(strobe), .state(state)
  );

  mlc_prog_dp #(
    .AMP_W(AMP_W), .GATE_W(GATE_W), .CUR_W(CUR_W), .CNT_W(CNT_W),
    .TMR_W(TMR_W), .TMR_MAX(TMR_MAX), .AMP_MAX(AMP_MAX),
    .FORM_START(FORM_START), .PROG_START(PROG_START),
    .FORM_GATE(FORM_GATE), .RESET_GATE(RESET_GATE),
    .SET_GATE_BASE(SET_GATE_BASE), .SET_GATE_STEP(SET_GATE_STEP),
    .FORM_UA(FORM_UA), .RESET_UA(RESET_UA), .SET_STEP_UA(SET_STEP_UA)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdOp(cmdOp), .cmdLevel(cmdLevel),
    .readCurrent(readCurrent), .active(busy), .tmr(tmr),
    .verifyPass(verifyPass), .ampAtMax(ampAtMax), .ampOut(pulseAmp),
    .gateOut(gateCode), .sourceSide(drvSource), .pulseCnt(pulseCount),
    .doneFlag(done), .failFlag(fail)
  );

  assign busy    = (state != ST_IDLE);
  assign pulseEn = (state == ST_PULSE);
  assign readReq = (state == ST_VERIFY);
endmodule

// File: rtl/mlc_prog_checker.sv
module mlc_prog_checker #(
  parameter int AMP_W = 5,
  parameter int GATE_W = 5,
  parameter int CNT_W = 5,
  parameter int AMP_MAX = 30,
  parameter int RESET_GATE = 27
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [CNT_W-1:0]  pulseCount,
  input logic [AMP_W-1:0]  pulseAmp,
  input logic [GATE_W-1:0] gateCode,
  input logic              drvSource,
  input logic              pulseEn,
  input logic              readReq
);
  logic [AMP_W-1:0] lastAmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastAmp <= '0;
    else if (pulseEn) lastAmp <= pulseAmp;
  end

  AST_AMP_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    pulseEn |-> pulseAmp <= AMP_W'(AMP_MAX)); // R8
  AST_PULSE_READ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(pulseEn && readReq)); // R2
  AST_AMP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (pulseEn && $past(pulseEn)) |-> $stable(pulseAmp)); // R3
  AST_AMP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pulseEn) && pulseCount > CNT_W'(1)) |-> pulseAmp == lastAmp + AMP_W'(1)); // R4
  AST_RESET_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (pulseEn && drvSource) |-> gateCode == GATE_W'(RESET_GATE)); // R5
  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail)); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !busy) |=> (done || busy)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!pulseEn && !readReq && pulseAmp == '0 && gateCode == '0 && !drvSource)); // R10
endmodule

bind mlc_prog_ctrl mlc_prog_checker #(
  .AMP_W(AMP_W), .GATE_W(GATE_W), .CNT_W(CNT_W), .AMP_MAX(AMP_MAX), .RESET_GATE(RESET_GATE)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .fail(fail),
  .pulseCount(pulseCount), .pulseAmp(pulseAmp), .gateCode(gateCode),
  .drvSource(drvSource), .pulseEn(pulseEn), .readReq(readReq)
);

// File: tb/tb_mlc_prog_ctrl.sv
module tb_mlc_prog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_CYC = 4;
  localparam int SETTLE_CYC = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [1:0] cmdLevel = '0;
  logic       busy, done, fail, drvSource, pulseEn, readReq;
  logic [4:0] pulseCount, pulseAmp, gateCode;
  logic       readValid = 1'b0;
  logic [7:0] readCurrent = '0;

  int nChecks = 0;
  int nFails = 0;

  // behavioural cell
  int cellOp = 0, cellThr = 1, cellSlope = 1, cellFormUa = 20, cellCur = 0;
  int latchAmp = 0;
  logic prevPe = 1'b0;
  // monitor state
  int mOp = 0, mLvl = 0, pulseIdx = 0, hiCnt = 0, gapCnt = 0;
  bit readSeen = 1'b1;
  logic prevRr = 1'b0;

  mlc_prog_ctrl #(.PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLevel(cmdLevel),
    .busy(busy), .done(done), .fail(fail), .pulseCount(pulseCount),
    .pulseAmp(pulseAmp), .gateCode(gateCode), .drvSource(drvSource),
    .pulseEn(pulseEn), .readReq(readReq), .readValid(readValid), .readCurrent(readCurrent)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cellStep(int op, int cur, int a);
    int v;
    if (a < cellThr) return cur;
    if (op == 0) return cellFormUa;
    if (op == 1) begin
      v = cur - (a - cellThr + 1) * cellSlope;
      return (v < 0) ? 0 : v;
    end
    v = (a - cellThr + 1) * cellSlope;
    if (v > 255) v = 255;
    return (v > cur) ? v : cur;
  endfunction

  function automatic bit meets(int op, int lvl, int cur);
    if (op == 0) return cur > 18;
    if (op == 1) return cur < 5;
    return cur >= 15 * (lvl + 1);
  endfunction

  function automatic int expGate(int op, int lvl);
    if (op == 0) return 15;
    if (op == 1) return 27;
    return 10 + 2 * lvl;
  endfunction

  // cell, read responder and cycle monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (pulseEn) latchAmp = pulseAmp;
      if (prevPe && !pulseEn) cellCur = cellStep(cellOp, cellCur, latchAmp);
      if (readReq && !readValid) begin
        readValid <= 1'b1;
        readCurrent <= (cellCur > 255) ? 8'd255 : 8'(cellCur);
      end else readValid <= 1'b0;

      if (pulseEn && !prevPe) begin
        chk(readSeen, "R2 read before pulse", 0, 1);
        readSeen = 1'b0;
        chk(pulseAmp == 5'((mOp == 0 ? 2 : 1) + pulseIdx), "R4 amplitude", pulseAmp,
            (mOp == 0 ? 2 : 1) + pulseIdx);
        chk(gateCode == 5'(expGate(mOp, mLvl)), mOp == 1 ? "R5 gate" : (mOp == 0 ? "R7 gate" : "R6 gate"),
            gateCode, expGate(mOp, mLvl));
        chk(drvSource == (mOp == 1), mOp == 1 ? "R5 side" : "R6 R7 side", drvSource, mOp == 1);
        pulseIdx++;
        hiCnt = 0;
      end
      if (pulseEn) hiCnt++;
      if (prevPe && !pulseEn) begin
        chk(hiCnt == PULSE_CYC, "R3 pulse width", hiCnt, PULSE_CYC);
        gapCnt = 0;
      end
      if (busy && !pulseEn && !readReq) gapCnt++;
      if (readReq && !prevRr) begin
        chk(gapCnt == SETTLE_CYC, "R3 settle gap", gapCnt, SETTLE_CYC);
        readSeen = 1'b1;
      end
      prevPe = pulseEn;
      prevRr = readReq;
    end
  end

  task automatic runCmd(input int op, input int lvl, input int startCur, input int thr,
                        input int slope, input int formUa, input bit interfere);
    int cur, n, a;
    bit ok;
    cellOp = op; cellThr = thr; cellSlope = slope; cellFormUa = formUa; cellCur = startCur;
    cur = startCur; n = 0; ok = 1'b0;
    for (a = (op == 0 ? 2 : 1); a <= 30; a++) begin
      n++;
      cur = cellStep(op, cur, a);
      if (meets(op, lvl, cur)) begin ok = 1'b1; break; end
    end
    mOp = op; mLvl = lvl; pulseIdx = 0; readSeen = 1'b1;
    @(negedge clk); cmdValid = 1'b1; cmdOp = 2'(op); cmdLevel = 2'(lvl);
    @(negedge clk); cmdValid = 1'b0;
    chk(busy && !done && !fail, "R9 clear on command", {busy, done, fail}, 3'b100);
    if (interfere) begin
      repeat (2) @(negedge clk);
      cmdValid = 1'b1; cmdOp = 2'((op + 1) % 3); cmdLevel = 2'(lvl ^ 1);
      @(negedge clk); cmdValid = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(done == ok && fail == !ok, ok ? (op == 1 ? "R5 done" : (op == 0 ? "R7 done" : "R6 done"))
        : "R8 fail", {done, fail}, {ok, !ok});
    chk(pulseCount == 5'(n), interfere ? "R1 busy command ignored" : "R9 pulse count", pulseCount, n);
    repeat (4) @(negedge clk);
    chk(done == ok && fail == !ok && pulseCount == 5'(n) && !busy, "R9 hold", pulseCount, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && pulseCount == 0 && !pulseEn && !readReq &&
        pulseAmp == 0 && gateCode == 0 && !drvSource, "R10 reset state",
        {busy, done, fail, pulseEn, readReq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // unused op code while idle
    cmdValid = 1'b1; cmdOp = 2'd3;
    @(negedge clk); cmdValid = 1'b0;
    @(negedge clk);
    chk(!busy && pulseCount == 0, "R1 op 3 ignored", busy, 0);

    runCmd(2, 0, 0, 1, 15, 20, 1'b0);   // R6 exact L2 threshold in one pulse
    runCmd(2, 3, 0, 1, 1, 20, 1'b0);    // R8 L5 unreachable
    runCmd(0, 0, 0, 1, 1, 18, 1'b0);    // R7 exactly 18 never passes
    runCmd(0, 0, 0, 5, 1, 19, 1'b0);    // R7 passes at amplitude 5
    runCmd(1, 0, 3, 10, 4, 20, 1'b0);   // R5 already low: one pulse
    runCmd(1, 0, 200, 3, 9, 20, 1'b1);  // R1 command during run
    runCmd(2, 2, 0, 4, 9, 20, 1'b1);    // R6 L4 with interference

    for (int t = 0; t < 40; t++) begin
      int op, lvl, sc;
      op = int'($urandom % 3);
      lvl = int'($urandom % 4);
      sc = (op == 1) ? 20 + int'($urandom % 120) : (op == 2 ? int'($urandom % 10) : 0);
      runCmd(op, lvl, sc, 1 + int'($urandom % 20), 1 + int'($urandom % 12),
             10 + int'($urandom % 20), (t % 5) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule